// File: doc/BRIEF.md
# Predicated Sign-Extending Vector Load

This block fills one vector register from memory. It reads consecutive 16-bit halfwords and sign-extends each one into a 32-bit lane of the destination. The first element sits at a base address plus an index counted in halfwords. Each lane has one predicate bit. A lane whose bit is clear never touches memory and is filled with zero. A lane whose bit is set fetches its halfword through a simple request/response port. Only one request is outstanding at any time, and the lanes are visited from lowest to highest.

A single-cycle start pulse captures the base, the index and the predicate. The block then assembles the result in a private staging area. When every lane has been filled, the whole vector is copied to the output in one step and a one-cycle done pulse marks it valid. If an active lane's response carries an error, the operation is abandoned. A fault pulse reports that lane's index, and the output vector is left exactly as it was. The vector width is a parameter from 128 to 2048 bits, which gives 4 to 64 lanes.

Top module: `hwld_seq`

## Requirements
- R1: An active lane receives the returned halfword sign-extended to 32 bits: bits 31:16 all equal bit 15 of the halfword.
- R2: An inactive lane is written as zero in the committed vector, whatever value that lane held before.
- R3: No memory request is ever issued for a lane whose predicate bit is 0, so an inactive lane can never raise a fault, even when its address is a faulting one.
- R4: The request address for lane i is base + 2*index + 2*i, computed modulo 2^ADDR_W.
- R5: Requests go out in strictly ascending lane order. mem_req_o is a one-cycle pulse, and no new request is issued until the response to the previous one has arrived.
- R6: done_o is a one-cycle pulse with busy_o low. vec_o takes its new value in the same cycle that done_o is high, and holds it until the next done_o.
- R7: An error response on an active lane produces a one-cycle fault_o pulse with fault_lane_o equal to that lane. After it, no further requests are issued, done_o does not pulse and vec_o is unchanged.
- R8: With an all-zero predicate the operation completes with done_o, issues no request and leaves vec_o all zero.
- R9: start_i is ignored while busy_o is high. The running operation keeps its captured base, index and predicate.
- R10: Predicate bit i controls lane i, and lane i occupies vec_o bits 32*i+31 down to 32*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin an operation; captures base, index and predicate when idle |
| base_i | input | ADDR_W | Byte base address |
| index_i | input | ADDR_W | Halfword index added to the base |
| pred_i | input | LANES | Per-lane enable, bit i for lane i |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested halfword |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | 16 | Returned halfword |
| mem_rsp_err_i | input | 1 | Response carries an error |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: vec_o holds the new result |
| vec_o | output | VLEN_BITS | Committed destination vector |
| fault_o | output | 1 | One-cycle pulse: the operation was aborted by an error |
| fault_lane_o | output | LANE_W | Lane that returned the error |

## Verification
A wrong lane counter or predicate copy shows up at the memory port straight away: a request appears for a disabled lane, or an address falls out of step with base + 2*index + 2*i. The bench's memory model catches this on the very request where it happens. Corrupted staging data, or a missing zero write, only becomes visible when the vector is committed, and it appears as a wrong lane value on the done_o cycle. A broken abort path shows in the fault cycle, as a done pulse, a changed vector or a further request. A sweep over every predicate pattern of a four-lane configuration, with varied latency, covers each ordering of active and inactive lanes.

// File: rtl/hwld_pkg.sv
package hwld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } hwld_state_e;

  localparam int unsigned HW_BITS   = 16;
  localparam int unsigned LANE_BITS = 32;

  function automatic logic [LANE_BITS-1:0] sext_hw(input logic [HW_BITS-1:0] h);
    return {{(LANE_BITS-HW_BITS){h[HW_BITS-1]}}, h};
  endfunction

endpackage

// File: rtl/hwld_agen.sv
module hwld_agen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] origin_q, origin_d;

  always_comb begin
    origin_d = origin_q;
    if (load_i) origin_d = base_i + (index_i << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) origin_q <= '0;
    else        origin_q <= origin_d;
  end

  assign addr_o = origin_q + ADDR_W'({lane_i, 1'b0});

endmodule

// File: rtl/hwld_vbuf.sv
module hwld_vbuf #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned EW     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [LANE_W-1:0]   wr_lane_i,
  input  logic [EW-1:0]       wr_data_i,
  input  logic                commit_i,
  output logic [LANES*EW-1:0] vec_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [EW-1:0] stage_q, stage_d;
    logic [EW-1:0] out_q, out_d;
    logic          hit;

    assign hit = wr_en_i && (wr_lane_i == LANE_W'(g));

    always_comb begin
      stage_d = stage_q;
      if (hit) stage_d = wr_data_i;
      out_d = out_q;
      if (commit_i) out_d = stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        out_q   <= '0;
      end else begin
        stage_q <= stage_d;
        out_q   <= out_d;
      end
    end

    assign vec_o[g*EW +: EW] = out_q;
  end

endmodule

// File: rtl/hwld_ctrl.sv
module hwld_ctrl
  import hwld_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANES-1:0]  pred_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              req_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              wr_en_o,
  output logic              wr_zero_o,
  output logic              commit_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [LANE_W-1:0] fault_lane_o
);

  hwld_state_e       state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LANES-1:0]  pred_q, pred_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  logic [LANE_W-1:0] flane_q, flane_d;
  logic              last;

  assign last = (lane_q == LANE_W'(LANES-1));

  always_comb begin
    state_d   = state_q;
    lane_d    = lane_q;
    pred_d    = pred_q;
    flane_d   = flane_q;
    done_d    = 1'b0;
    fault_d   = 1'b0;
    accept_o  = 1'b0;
    req_o     = 1'b0;
    wr_en_o   = 1'b0;
    wr_zero_o = 1'b0;
    commit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          pred_d   = pred_i;
          lane_d   = '0;
          state_d  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (pred_q[lane_q]) begin
          req_o   = 1'b1;
          state_d = ST_WAIT;
        end else begin
          wr_en_o   = 1'b1;
          wr_zero_o = 1'b1;
          if (last) state_d = ST_DONE;
          else      lane_d  = lane_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            fault_d = 1'b1;
            flane_d = lane_q;
            state_d = ST_IDLE;
          end else begin
            wr_en_o = 1'b1;
            if (last) begin
              state_d = ST_DONE;
            end else begin
              lane_d  = lane_q + 1'b1;
              state_d = ST_SCAN;
            end
          end
        end
      end
      ST_DONE: begin
        commit_o = 1'b1;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      pred_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flane_q <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      pred_q  <= pred_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      flane_q <= flane_d;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign lane_o       = lane_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_lane_o = flane_q;

  // R5: a request is never followed directly by another one
  a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: an aborted operation never also completes
  a_r7_fault_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !done_o);

endmodule

// File: rtl/hwld_seq.sv
module hwld_seq
  import hwld_pkg::*;
#(
  parameter int unsigned VLEN_BITS = 128,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned LANES    = VLEN_BITS / LANE_BITS,
  localparam int unsigned LANE_W   = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    index_i,
  input  logic [LANES-1:0]     pred_i,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [HW_BITS-1:0]   mem_rsp_data_i,
  input  logic                 mem_rsp_err_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [VLEN_BITS-1:0] vec_o,
  output logic                 fault_o,
  output logic [LANE_W-1:0]    fault_lane_o
);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_s;
  logic                 accept;
  logic [LANE_W-1:0]    lane;
  logic                 wr_en;
  logic                 wr_zero;
  logic                 commit;
  logic [LANE_BITS-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  hwld_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start_i),
    .pred_i       (pred_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_err_i    (mem_rsp_err_i),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .req_o        (mem_req_o),
    .lane_o       (lane),
    .wr_en_o      (wr_en),
    .wr_zero_o    (wr_zero),
    .commit_o     (commit),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_lane_o (fault_lane_o)
  );

  hwld_agen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) agen_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_i  (accept),
    .base_i  (base_i),
    .index_i (index_i),
    .lane_i  (lane),
    .addr_o  (mem_addr_o)
  );

  assign wr_data = wr_zero ? '0 : sext_hw(mem_rsp_data_i);

  hwld_vbuf #(.LANES(LANES), .LANE_W(LANE_W), .EW(LANE_BITS)) vbuf_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (wr_en),
    .wr_lane_i (lane),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .vec_o     (vec_o)
  );

  // R7: nothing is requested in the cycle a fault is reported
  a_r7_no_req_after_fault: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault_o |-> !mem_req_o);

  // R6: the done pulse finds the sequencer idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);

  // R6: the committed vector only moves together with done
  a_r6_vec_with_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(vec_o) |-> done_o);

endmodule

// File: tb/hwld_seq_tb.sv
module hwld_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  base_i;
  logic [31:0]  index_i;
  logic [3:0]   pred_i;
  logic         mem_req_o;
  logic [31:0]  mem_addr_o;
  logic         mem_rsp_valid_i;
  logic [15:0]  mem_rsp_data_i;
  logic         mem_rsp_err_i;
  logic         busy_o;
  logic         done_o;
  logic [127:0] vec_o;
  logic         fault_o;
  logic [1:0]   fault_lane_o;

  int checks;
  int errors;

  logic [31:0] cur_start;
  logic [3:0]  cur_pred;
  int          req_cnt;
  int          last_lane;
  int          pend;
  logic [31:0] pend_addr;
  int          lat;
  logic        bad_en;
  logic [31:0] bad_addr;

  hwld_seq #(.VLEN_BITS(128), .ADDR_W(32)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .base_i          (base_i),
    .index_i         (index_i),
    .pred_i          (pred_i),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .vec_o           (vec_o),
    .fault_o         (fault_o),
    .fault_lane_o    (fault_lane_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_hw(input logic [31:0] a);
    logic [31:0] t;
    t = (a >> 1) * 32'd40503 + 32'd12345;
    return t[23:8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and request monitor, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid_i = 1'b0;
      mem_rsp_err_i   = 1'b0;
      mem_rsp_data_i  = '0;
      pend            = 0;
    end else begin
      int lane_no;
      logic [31:0] off;
      mem_rsp_valid_i = 1'b0;
      mem_rsp_err_i   = 1'b0;
      if (mem_req_o) begin
        off     = mem_addr_o - cur_start;
        lane_no = int'(off >> 1);
        chk(pend == 0, "R5 request while one is outstanding", 128'(pend), 128'd0);
        chk(off[0] == 1'b0 && off < 32'(2*LANES), "R4 request address", 128'(mem_addr_o), 128'(cur_start));
        if (off < 32'(2*LANES)) begin
          chk(cur_pred[lane_no] == 1'b1, "R3 request for inactive lane", 128'(lane_no), 128'(cur_pred));
          chk(lane_no > last_lane, "R5 lane order", 128'(lane_no), 128'(last_lane + 1));
          last_lane = lane_no;
        end
        req_cnt++;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_hw(pend_addr);
          mem_rsp_err_i   = bad_en && (pend_addr == bad_addr);
        end
      end
      if (mem_req_o) begin
        pend      = lat;
        pend_addr = mem_addr_o;
      end
    end
  end

  task automatic run_op(input logic [31:0] b, input logic [31:0] x, input logic [3:0] p,
                        input bit inject, output bit got_done, output bit got_fault);
    cur_start = b + (x << 1);
    cur_pred  = p;
    req_cnt   = 0;
    last_lane = -1;
    got_done  = 1'b0;
    got_fault = 1'b0;
    @(negedge clk);
    start_i = 1'b1; base_i = b; index_i = x; pred_i = p;
    @(negedge clk);
    start_i = 1'b0; base_i = '0; index_i = '0; pred_i = '0;
    if (inject) begin
      @(negedge clk);
      chk(busy_o == 1'b1, "R9 busy before second start", 128'(busy_o), 128'd1);
      start_i = 1'b1; base_i = 32'h7000_0000; index_i = 32'h55; pred_i = ~p;
      @(negedge clk);
      start_i = 1'b0; base_i = '0; index_i = '0; pred_i = '0;
    end
    for (int k = 0; k < 400; k++) begin
      if (done_o) got_done = 1'b1;
      if (fault_o) got_fault = 1'b1;
      if (got_done || got_fault) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [127:0] expect_vec(input logic [31:0] st, input logic [3:0] p);
    logic [127:0] v;
    logic [15:0]  h;
    v = '0;
    for (int i = 0; i < LANES; i++) begin
      h = mem_hw(st + 32'(2*i));
      if (p[i]) v[i*32 +: 32] = {{16{h[15]}}, h};
    end
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit          gd;
    bit          gf;
    logic [127:0] ev;
    logic [127:0] prev;
    checks  = 0;
    errors  = 0;
    start_i = 1'b0; base_i = '0; index_i = '0; pred_i = '0;
    lat = 1; bad_en = 1'b0; bad_addr = '0;
    cur_start = '0; cur_pred = '0; req_cnt = 0; last_lane = -1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vec_o == '0, "R6 reset vector", vec_o, '0);
    chk(!done_o && !busy_o && !fault_o && !mem_req_o, "R6 reset outputs",
        128'({done_o, busy_o, fault_o, mem_req_o}), 128'd0);

    // R8: all lanes disabled, nothing fetched
    run_op(32'h0000_2000, 32'd5, 4'b0000, 1'b0, gd, gf);
    chk(gd && !gf, "R8 completes", 128'({gd, gf}), 128'b10);
    chk(req_cnt == 0, "R8 no requests", 128'(req_cnt), 128'd0);
    chk(vec_o == '0, "R8 zero vector", vec_o, '0);

    // sweep every predicate with varied latency (R1 R2 R3 R4 R5 R10)
    for (int p = 15; p >= 0; p--) begin
      logic [31:0] b;
      logic [31:0] x;
      b   = 32'h0000_1000 + 32'(p * 64) + 32'(p % 2);
      x   = 32'(p * 3 + 1);
      lat = (p % 3) + 1;
      run_op(b, x, 4'(p), 1'b0, gd, gf);
      ev = expect_vec(b + (x << 1), 4'(p));
      chk(gd && !gf, "R6 sweep completes", 128'({gd, gf}), 128'b10);
      chk(req_cnt == $countones(4'(p)), "R3 request count", 128'(req_cnt), 128'($countones(4'(p))));
      for (int i = 0; i < LANES; i++)
        chk(vec_o[i*32 +: 32] == ev[i*32 +: 32],
            p[i] ? "R1 R10 active lane value" : "R2 R10 inactive lane zero",
            128'(vec_o[i*32 +: 32]), 128'(ev[i*32 +: 32]));
      @(negedge clk);
      chk(!done_o, "R6 done lasts one cycle", 128'(done_o), 128'd0);
      chk(vec_o == ev, "R6 vector holds", vec_o, ev);
    end

    // address wrap (R4)
    lat = 2;
    run_op(32'hFFFF_FFF8, 32'd2, 4'b1111, 1'b0, gd, gf);
    ev = expect_vec(32'hFFFF_FFFC, 4'b1111);
    chk(gd && vec_o == ev, "R4 wrapped addresses", vec_o, ev);

    // R9: start while busy is ignored
    lat = 3;
    run_op(32'h0000_4000, 32'd9, 4'b0110, 1'b1, gd, gf);
    ev = expect_vec(32'h0000_4000 + 32'd18, 4'b0110);
    chk(gd && !gf, "R9 original op completes", 128'({gd, gf}), 128'b10);
    chk(vec_o == ev, "R9 operands kept", vec_o, ev);
    chk(req_cnt == 2, "R9 request count", 128'(req_cnt), 128'd2);

    // R3: faulting address on an inactive lane never faults
    bad_en   = 1'b1;
    bad_addr = 32'h0000_5000 + 32'd4;
    lat = 1;
    run_op(32'h0000_5000, 32'd0, 4'b1011, 1'b0, gd, gf);
    ev = expect_vec(32'h0000_5000, 4'b1011);
    chk(gd && !gf, "R3 inactive bad lane no fault", 128'({gd, gf}), 128'b10);
    chk(vec_o == ev, "R3 vector with skipped bad lane", vec_o, ev);

    // R7: fault on active lane 2
    prev = vec_o;
    run_op(32'h0000_5000, 32'd0, 4'b1111, 1'b0, gd, gf);
    chk(gf && !gd, "R7 fault reported", 128'({gd, gf}), 128'b01);
    chk(fault_lane_o == 2'd2, "R7 fault lane", 128'(fault_lane_o), 128'd2);
    chk(vec_o == prev, "R7 vector unchanged", vec_o, prev);
    @(negedge clk);
    chk(!fault_o, "R7 fault one cycle", 128'(fault_o), 128'd0);
    repeat (5) begin
      @(negedge clk);
      chk(!mem_req_o && !done_o, "R7 no activity after fault", 128'({mem_req_o, done_o}), 128'd0);
    end
    chk(req_cnt == 3, "R7 requests stop at faulting lane", 128'(req_cnt), 128'd3);
    bad_en = 1'b0;

    // recovers after a fault
    run_op(32'h0000_5000, 32'd0, 4'b1111, 1'b0, gd, gf);
    ev = expect_vec(32'h0000_5000, 4'b1111);
    chk(gd && vec_o == ev, "R1 load after fault", vec_o, ev);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule